// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between the raw interrupt pins of a processor and its core. It brings a level-sensitive maskable request and an edge-triggered non-maskable request into the clock domain. The maskable request is gated by the core's interrupt-enable flag, while the non-maskable one ignores that flag. The block then tells the core, at an instruction boundary, which interrupt to take and with which vector.

A maskable interrupt is serviced with two acknowledge bus cycles. The first cycle's data is thrown away and the byte returned by the second cycle becomes the vector. A non-maskable interrupt skips the bus entirely and delivers a fixed vector.

The non-maskable input only counts after it has been low for a minimum run and then high for a minimum run. When both kinds are pending, the non-maskable one is taken first. Vector table lookup and state saving belong to the core.

The controller has four states:
- `ST_IDLE` waits for a boundary strobe.
- `ST_ACK_FIRST` drives the first acknowledge cycle.
- `ST_ACK_SECOND` drives the second acknowledge cycle and captures the vector.
- `ST_DELIVER` raises the vector-valid pulse for one clock.

Its transitions are:
- **idle→deliver**: taken when a pending non-maskable event is accepted at a boundary.
- **idle→ack-first**: taken when a qualified, enabled maskable request is present at a boundary and no non-maskable event is pending.
- **ack-first→ack-second**: taken on ready.
- **ack-second→deliver**: taken on ready, which also captures the vector.
- **deliver→idle**: taken unconditionally.

Top module: `irq_front_end`

## Requirements
- R1: After reset, `ack_req`, `vec_valid` and `vec_is_nmi` are 0 and `vec_out` is 0.
- R2: A maskable request that has been seen high through the synchronizer for at least `INTR_LEAD` consecutive clocks is taken at a `boundary` strobe while `ie_flag` is 1. In the clock after that strobe, `ack_req` is 1 and `ack_second` is 0.
- R3: While `ie_flag` is 0, a high maskable request has no effect: a boundary strobe leaves `ack_req` and `vec_valid` at 0.
- R4: An acknowledge sequence is two bus cycles, each finished by `ack_rdy`=1 at a clock edge. `ack_second` is 0 during the first cycle and 1 during the second. Clocks with `ack_rdy`=0 extend the current cycle. Only the `ack_data` present when the second cycle completes becomes the vector; the first cycle's data is discarded.
- R5: `vec_valid` is high for exactly one clock, in the clock after the vector is captured. `vec_out` keeps that value until the next interrupt is taken.
- R6: A taken non-maskable event drives `vec_valid` in the clock after the boundary strobe, with `vec_out` = `NMI_VECTOR` (default 2) and `vec_is_nmi` = 1. It performs no acknowledge cycle, and `ie_flag` does not affect it.
- R7: A rising edge of the synchronized non-maskable input becomes an event only after at least `NMI_LOW_MIN` low clocks before it and `NMI_HIGH_MIN` high clocks from it. A shorter high pulse, or a rise after a shorter low gap, is discarded.
- R8: When a non-maskable event and a qualified, enabled maskable request are both present at a boundary, the non-maskable one is taken. The maskable request is served at a later boundary.
- R9: A non-maskable event stays pending until a boundary accepts it. Further events that qualify while it is pending are dropped, not queued.
- R10: A boundary strobe is ignored while an interrupt is in progress. A maskable request that rises in the same clock as the boundary is not taken at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_in | input | 1 | Raw maskable request, level, active high, asynchronous |
| nmi_in | input | 1 | Raw non-maskable request, asynchronous |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| boundary | input | 1 | One-clock strobe at an instruction boundary |
| ack_req | output | 1 | Acknowledge bus cycle in progress |
| ack_second | output | 1 | 0 = first acknowledge cycle, 1 = second |
| ack_rdy | input | 1 | Ends the current acknowledge cycle |
| ack_data | input | VEC_W | Data bus during acknowledge |
| vec_valid | output | 1 | One-clock pulse: vector ready |
| vec_out | output | VEC_W | Vector of the interrupt taken |
| vec_is_nmi | output | 1 | 1 when the last vector came from the non-maskable path |

## Verification
The bench builds the block with its defaults: two synchronizer stages, four-clock low and high minimums, a two-clock maskable lead, and an 8-bit vector of which the non-maskable value is 2. These small widths let a two-clock pulse or gap fall short of qualification, and let a second qualified edge arrive while the first is still pending, within a few dozen clocks. Wait states on each acknowledge cycle, and a boundary strobe during a long acknowledge, reach the states where events overlap.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ACK_FIRST  = 2'd1,
        ST_ACK_SECOND = 2'd2,
        ST_DELIVER    = 2'd3
    } irq_state_t;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/irq_fe_sync.sv
module irq_fe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[b] <= '0;
            end else begin
                chain[b] <= {chain[b][STAGES-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain[b][STAGES-1];
    end

endmodule

// File: rtl/irq_fe_level_age.sv
module irq_fe_level_age
    import irq_fe_pkg::*;
#(
    parameter int LEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic qualified
);

    localparam int AW = cnt_bits(LEAD);

    logic [AW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (!level) begin
            age <= '0;
        end else if (age < AW'(LEAD)) begin
            age <= age + 1'b1;
        end
    end

    assign qualified = level && (age >= AW'(LEAD));

    // R2: a qualified request was already high in the previous clock
    a_r2_lead_seen: assert property (@(posedge clk) disable iff (!rst_n)
        qualified |-> $past(level));

endmodule

// File: rtl/irq_fe_nmi_qual.sv
module irq_fe_nmi_qual
    import irq_fe_pkg::*;
#(
    parameter int LOW_MIN  = 4,
    parameter int HIGH_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    input  logic take,
    output logic pending
);

    localparam int LW = cnt_bits(LOW_MIN);
    localparam int HW = cnt_bits(HIGH_MIN);

    logic          s_prev;
    logic [LW-1:0] low_cnt;
    logic [HW-1:0] hi_run;
    logic          armed;
    logic          low_ok;
    logic          rise;
    logic          evt;

    assign low_ok = (low_cnt >= LW'(LOW_MIN));
    assign rise   = s_in && !s_prev;
    assign evt    = armed && s_in && (hi_run == HW'(HIGH_MIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_prev  <= 1'b0;
            low_cnt <= '0;
            hi_run  <= '0;
            armed   <= 1'b0;
        end else begin
            s_prev <= s_in;
            if (!s_in) begin
                hi_run <= '0;
                armed  <= 1'b0;
                if (!low_ok) begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end else begin
                low_cnt <= '0;
                if (rise) begin
                    armed  <= low_ok;
                    hi_run <= HW'(1);
                end else if (armed) begin
                    if (evt) begin
                        armed <= 1'b0;
                    end else begin
                        hi_run <= hi_run + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (take) begin
            pending <= 1'b0;
        end else if (evt) begin
            pending <= 1'b1;
        end
    end

    // R7: a rise after too short a low gap never arms
    a_r7_short_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !low_ok) |=> !armed);

    // R7: an event only fires while the input is high and was high before
    a_r7_evt_high: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (s_in && $past(s_in)));

    // R9: pending holds until accepted
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !take) |=> pending);

endmodule

// File: rtl/irq_fe_ctrl.sv
module irq_fe_ctrl
    import irq_fe_pkg::*;
#(
    parameter int          VEC_W      = 8,
    parameter int unsigned NMI_VECTOR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             nmi_pend,
    input  logic             mreq_ok,
    input  logic             ack_rdy,
    input  logic [VEC_W-1:0] ack_data,
    output logic             nmi_take,
    output logic             ack_req,
    output logic             ack_second,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_is_nmi
);

    irq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (boundary && nmi_pend) begin
                    state_nx = ST_DELIVER;
                end else if (boundary && mreq_ok) begin
                    state_nx = ST_ACK_FIRST;
                end
            end
            ST_ACK_FIRST:  if (ack_rdy) state_nx = ST_ACK_SECOND;
            ST_ACK_SECOND: if (ack_rdy) state_nx = ST_DELIVER;
            ST_DELIVER:    state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        nmi_take   = 1'b0;
        ack_req    = 1'b0;
        ack_second = 1'b0;
        vec_valid  = 1'b0;
        unique case (state)
            ST_IDLE:       nmi_take = boundary && nmi_pend;
            ST_ACK_FIRST:  ack_req  = 1'b1;
            ST_ACK_SECOND: begin
                ack_req    = 1'b1;
                ack_second = 1'b1;
            end
            ST_DELIVER:    vec_valid = 1'b1;
            default:       ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_out    <= '0;
            vec_is_nmi <= 1'b0;
        end else if (nmi_take) begin
            vec_out    <= VEC_W'(NMI_VECTOR);
            vec_is_nmi <= 1'b1;
        end else if (state == ST_ACK_SECOND && ack_rdy) begin
            vec_out    <= ack_data;
            vec_is_nmi <= 1'b0;
        end
    end

    // R5: the valid pulse lasts one clock
    a_r5_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R5: the vector changes only when a new one is delivered
    a_r5_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vec_out) |-> vec_valid);

    // R4: second-cycle data becomes the vector
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_second && ack_rdy) |=> (vec_valid && vec_out == $past(ack_data)));

    // R6: accepted non-maskable event delivers the fixed vector without bus cycles
    a_r6_nmi_vec: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> (vec_valid && !ack_req && vec_is_nmi && vec_out == VEC_W'(NMI_VECTOR)));

    // R8: no acknowledge starts while a non-maskable event is accepted
    a_r8_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && boundary && nmi_pend) |=> !ack_req);

    // R10: a boundary strobe does not disturb an acknowledge cycle waiting on ready
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_rdy) |=> (ack_req && $stable(ack_second)));

    a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_req, vec_valid}));

endmodule

// File: rtl/irq_front_end.sv
module irq_front_end
    import irq_fe_pkg::*;
#(
    parameter int          VEC_W        = 8,
    parameter int          SYNC_STAGES  = 2,
    parameter int          NMI_LOW_MIN  = 4,
    parameter int          NMI_HIGH_MIN = 4,
    parameter int          INTR_LEAD    = 2,
    parameter int unsigned NMI_VECTOR   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreq_in,
    input  logic             nmi_in,
    input  logic             ie_flag,
    input  logic             boundary,
    output logic             ack_req,
    output logic             ack_second,
    input  logic             ack_rdy,
    input  logic [VEC_W-1:0] ack_data,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_is_nmi
);

    logic [1:0] sync_pins;
    logic       mreq_qual;
    logic       nmi_pend;
    logic       nmi_take;

    irq_fe_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({nmi_in, mreq_in}),
        .sync_out (sync_pins)
    );

    irq_fe_level_age #(
        .LEAD (INTR_LEAD)
    ) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (sync_pins[0]),
        .qualified (mreq_qual)
    );

    irq_fe_nmi_qual #(
        .LOW_MIN  (NMI_LOW_MIN),
        .HIGH_MIN (NMI_HIGH_MIN)
    ) u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_in    (sync_pins[1]),
        .take    (nmi_take),
        .pending (nmi_pend)
    );

    irq_fe_ctrl #(
        .VEC_W      (VEC_W),
        .NMI_VECTOR (NMI_VECTOR)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .nmi_pend   (nmi_pend),
        .mreq_ok    (mreq_qual && ie_flag),
        .ack_rdy    (ack_rdy),
        .ack_data   (ack_data),
        .nmi_take   (nmi_take),
        .ack_req    (ack_req),
        .ack_second (ack_second),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out),
        .vec_is_nmi (vec_is_nmi)
    );

    // R3: with the enable flag clear, an idle boundary without a non-maskable event starts nothing
    a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !ie_flag && !nmi_pend && !ack_req && !vec_valid) |=> (!ack_req && !vec_valid));

endmodule

// File: tb/irq_front_end_test.sv
module irq_front_end_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mreq_in = 1'b0;
    logic       nmi_in = 1'b0;
    logic       ie_flag = 1'b0;
    logic       boundary = 1'b0;
    logic       ack_rdy = 1'b0;
    logic [7:0] ack_data = 8'h00;
    logic       ack_req;
    logic       ack_second;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic       vec_is_nmi;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    irq_front_end #(
        .VEC_W        (8),
        .SYNC_STAGES  (2),
        .NMI_LOW_MIN  (4),
        .NMI_HIGH_MIN (4),
        .INTR_LEAD    (2),
        .NMI_VECTOR   (2)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mreq_in    (mreq_in),
        .nmi_in     (nmi_in),
        .ie_flag    (ie_flag),
        .boundary   (boundary),
        .ack_req    (ack_req),
        .ack_second (ack_second),
        .ack_rdy    (ack_rdy),
        .ack_data   (ack_data),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out),
        .vec_is_nmi (vec_is_nmi)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_boundary();
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
    endtask

    task automatic expect_nothing(input string tag);
        chk(ack_req == 1'b0, tag, ack_req, 0);
        chk(vec_valid == 1'b0, tag, vec_valid, 0);
    endtask

    task automatic nmi_shape(input int hi, input int lo);
        @(negedge clk) nmi_in = 1'b1;
        idle(hi - 1);
        @(negedge clk) nmi_in = 1'b0;
        idle(lo - 1);
    endtask

    task automatic expect_nmi(input string tag);
        chk(vec_valid == 1'b1, tag, vec_valid, 1);
        chk(vec_out == 8'h02, tag, vec_out, 2);
        chk(vec_is_nmi == 1'b1, tag, vec_is_nmi, 1);
        chk(ack_req == 1'b0, tag, ack_req, 0);
        @(negedge clk);
        chk(vec_valid == 1'b0, {tag, " pulse end"}, vec_valid, 0);
    endtask

    // Called at a negedge with the first acknowledge cycle active.
    task automatic run_ack(input logic [7:0] first, input logic [7:0] second,
                           input int w1, input int w2, input string tag);
        chk(ack_req && !ack_second, {tag, " R4 first cycle"}, {ack_req, ack_second}, 2);
        for (int i = 0; i < w1; i++) begin
            ack_rdy = 1'b0;
            @(negedge clk);
            chk(ack_req && !ack_second, {tag, " R4 wait1"}, {ack_req, ack_second}, 2);
        end
        ack_rdy = 1'b1;
        ack_data = first;
        @(negedge clk);
        ack_rdy = 1'b0;
        ack_data = 8'hEE;
        chk(ack_req && ack_second, {tag, " R4 second cycle"}, {ack_req, ack_second}, 3);
        chk(vec_valid == 1'b0, {tag, " R4 no early valid"}, vec_valid, 0);
        for (int i = 0; i < w2; i++) begin
            @(negedge clk);
            chk(ack_req && ack_second && !vec_valid, {tag, " R4 wait2"},
                {ack_req, ack_second, vec_valid}, 6);
        end
        ack_rdy = 1'b1;
        ack_data = second;
        @(negedge clk);
        ack_rdy = 1'b0;
        ack_data = 8'hEE;
        chk(vec_valid == 1'b1, {tag, " R5 valid"}, vec_valid, 1);
        chk(vec_out == second, {tag, " R4 second byte"}, vec_out, second);
        chk(vec_is_nmi == 1'b0, {tag, " R4 maskable kind"}, vec_is_nmi, 0);
        chk(ack_req == 1'b0, {tag, " R4 bus done"}, ack_req, 0);
        @(negedge clk);
        chk(vec_valid == 1'b0, {tag, " R5 one clock"}, vec_valid, 0);
        chk(vec_out == second, {tag, " R5 hold"}, vec_out, second);
    endtask

    task automatic t_reset();
        chk(ack_req == 1'b0, "R1 ack_req", ack_req, 0);
        chk(vec_valid == 1'b0, "R1 vec_valid", vec_valid, 0);
        chk(vec_out == 8'h00, "R1 vec_out", vec_out, 0);
        chk(vec_is_nmi == 1'b0, "R1 vec_is_nmi", vec_is_nmi, 0);
    endtask

    task automatic t_maskable_basic();
        ie_flag = 1'b1;
        mreq_in = 1'b1;
        idle(6);
        pulse_boundary();
        chk(ack_req == 1'b1, "R2 ack started", ack_req, 1);
        run_ack(8'h33, 8'hA7, 0, 0, "basic");
        mreq_in = 1'b0;
        idle(4);
        chk(vec_out == 8'hA7, "R5 holds later", vec_out, 8'hA7);
    endtask

    task automatic t_wait_states();
        mreq_in = 1'b1;
        idle(6);
        pulse_boundary();
        run_ack(8'hC3, 8'h5C, 2, 3, "waits");
        mreq_in = 1'b0;
        idle(4);
    endtask

    task automatic t_ie_clear();
        ie_flag = 1'b0;
        mreq_in = 1'b1;
        idle(6);
        pulse_boundary();
        expect_nothing("R3 masked");
        idle(2);
        expect_nothing("R3 masked later");
        chk(vec_out == 8'h5C, "R3 vector untouched", vec_out, 8'h5C);
        mreq_in = 1'b0;
        idle(4);
    endtask

    task automatic t_late();
        ie_flag = 1'b1;
        @(negedge clk);
        mreq_in = 1'b1;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        expect_nothing("R10 late request");
        mreq_in = 1'b0;
        idle(4);
        expect_nothing("R10 late request after");
    endtask

    task automatic t_nmi_basic();
        ie_flag = 1'b0;
        nmi_shape(8, 10);
        pulse_boundary();
        expect_nmi("R6 nmi with ie clear");
    endtask

    task automatic t_nmi_short();
        nmi_shape(2, 10);
        pulse_boundary();
        expect_nothing("R7 short high rejected");
        // valid high run, taken while still high, then too short a low gap
        @(negedge clk) nmi_in = 1'b1;
        idle(8);
        pulse_boundary();
        expect_nmi("R7 first valid pulse");
        @(negedge clk) nmi_in = 1'b0;
        idle(1);
        nmi_shape(8, 10);
        pulse_boundary();
        expect_nothing("R7 short low rejected");
    endtask

    task automatic t_nmi_drop();
        nmi_shape(8, 8);
        nmi_shape(8, 10);
        pulse_boundary();
        expect_nmi("R9 first taken");
        pulse_boundary();
        expect_nothing("R9 second dropped");
    endtask

    task automatic t_priority();
        ie_flag = 1'b1;
        mreq_in = 1'b1;
        nmi_shape(8, 10);
        pulse_boundary();
        expect_nmi("R8 nmi first");
        pulse_boundary();
        run_ack(8'h11, 8'h91, 0, 1, "R8 maskable next");
        mreq_in = 1'b0;
        idle(4);
    endtask

    task automatic t_busy();
        ie_flag = 1'b1;
        mreq_in = 1'b1;
        idle(6);
        pulse_boundary();
        chk(ack_req && !ack_second, "R10 ack begun", {ack_req, ack_second}, 2);
        mreq_in = 1'b0;
        nmi_shape(8, 10);
        pulse_boundary();
        chk(ack_req && !ack_second, "R10 boundary ignored while busy",
            {ack_req, ack_second}, 2);
        chk(vec_valid == 1'b0, "R10 no nmi while busy", vec_valid, 0);
        run_ack(8'h22, 8'h4E, 0, 0, "R10 finish");
        pulse_boundary();
        expect_nmi("R10 nmi after busy");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        idle(6);
        t_maskable_basic();
        t_wait_states();
        t_ie_clear();
        t_late();
        t_nmi_basic();
        t_nmi_short();
        t_nmi_drop();
        t_priority();
        t_busy();
        idle(4);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule